// File: doc/BRIEF.md
# Configuration Frame Receiver with Acknowledge

This block sits behind a pulse-width decoder on a single-wire command interface. A strobe from the decoder marks a detected configuration/status command. The block then assembles the bit stream that follows into a frame and checks it.

Each frame opens with a direction bit and a 4-bit subcommand index, both sent MSB first. A read frame ends there, and the block raises a read request carrying the index. A write frame goes on with a data field, whose length the index selects from a fixed table, and then an 8-bit checksum. The block delivers the data right-aligned on a wide parallel bus. It asks for an acknowledge bit whose value tells whether the checksum matched, and it raises a write strobe only for a good frame whose index accepts writes.

After a frame is complete, any further bits are dropped until the next command strobe. A timeout strobe aborts a frame that is still open.

Top module: `cfg_frame_rx`

## Requirements
- R1: After reset `wr_stb`, `rd_stb` and `ack_vld` are low and `data_o` is all zeros.
- R2: Only `cmd_det` while idle opens a frame. Bits that arrive while idle produce no strobe and no acknowledge.
- R3: The first frame bit is the direction (1 = write, 0 = read), followed by the index MSB first. A read frame ends after these 5 bits with a one-cycle `rd_stb`, `idx_o` equal to the index, and no acknowledge.
- R4: Write data lengths in bits, by index: 0:8, 1:24, 2:8, 3:18, 4:8, 5:124, 6:124, 7:42, 8:56, 9:160, 10:46, 11:8, 12:1024, 13:352, 14:0, 15:16. On `wr_stb`, `data_o` holds the data bits with the last received bit at bit 0 and zeros above the field.
- R5: The checksum is sent MSB first. It is the bitwise inverse of the 8-bit end-around-carry sum of the bytes formed MSB first from the direction bit through the last data bit, with the final byte padded with trailing zeros.
- R6: A write frame with a matching checksum yields a one-cycle `ack_vld` with `ack_val` = 1 in the cycle after its last checksum bit.
- R7: A write frame with a mismatching checksum yields `ack_vld` with `ack_val` = 0 and no `wr_stb`.
- R8: `wr_stb` accompanies a good acknowledge only when the index is writable. Indices 0, 1, 12, 15 (read-only) and 14 (reserved) are acknowledged but never strobed.
- R9: Bits following a complete frame are ignored. They cause no further strobe or acknowledge.
- R10: A `cmd_det` pulse during an open frame is ignored, and the frame continues.
- R11: `tmo` during an open frame aborts it. It yields no `wr_stb`, `rd_stb` or `ack_vld`, and the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_det | input | 1 | Configuration command detected strobe |
| bit_vld | input | 1 | Decoded bit valid |
| bit_in | input | 1 | Decoded bit value |
| tmo | input | 1 | Frame timeout strobe |
| idx_o | output | 4 | Subcommand index of the current/last frame |
| data_o | output | DW | Received data, right-aligned |
| wr_stb | output | 1 | Apply write (good checksum, writable index) |
| rd_stb | output | 1 | Read request for `idx_o` |
| ack_vld | output | 1 | Request to send an acknowledge bit |
| ack_val | output | 1 | Acknowledge value (1 good, 0 bad checksum) |

## Verification
The assertions check on every cycle that each write strobe comes with a positive acknowledge and that a negative acknowledge never comes with one. They also check that read-only or reserved indices are never strobed, that a read request never brings an acknowledge, that acknowledges are single pulses, and that a timeout silences the outputs in the following cycle. Other behaviours can only be shown by the bench scenarios against its own checksum and length model. These are the exact data contents and alignment for every table length, the checksum padding, corrupted checksum and data bits, surplus bits, stray command pulses mid-frame, and recovery after a timeout.

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx #(
  parameter int DW = 1024,
  parameter int IW = 4,
  parameter int CSW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_det,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic          tmo,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] data_o,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic          ack_vld,
  output logic          ack_val
);
  localparam int CW = $clog2(DW + 1);
  localparam int BW = $clog2(CSW);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_CSUM} st_t;

  function automatic logic [CW-1:0] len_of(input logic [IW-1:0] i);
    case (i)
      4'd1:    return CW'(24);
      4'd3:    return CW'(18);
      4'd5:    return CW'(124);
      4'd6:    return CW'(124);
      4'd7:    return CW'(42);
      4'd8:    return CW'(56);
      4'd9:    return CW'(160);
      4'd10:   return CW'(46);
      4'd12:   return CW'(1024);
      4'd13:   return CW'(352);
      4'd14:   return CW'(0);
      4'd15:   return CW'(16);
      default: return CW'(8);
    endcase
  endfunction

  function automatic logic writable(input logic [IW-1:0] i);
    return !(i inside {4'd0, 4'd1, 4'd12, 4'd14, 4'd15});
  endfunction

  function automatic logic [CSW-1:0] eac(input logic [CSW-1:0] a, input logic [CSW-1:0] b);
    logic [CSW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CSW-1:0] + {{(CSW-1){1'b0}}, s[CSW]};
  endfunction

  st_t            st;
  logic           rw;
  logic [IW-1:0]  idx;
  logic [CW-1:0]  cnt, dlen;
  logic [CSW-1:0] sum, acc, cs_sh;
  logic [BW-1:0]  nb;
  logic [DW-1:0]  data;

  wire            take    = bit_vld && !tmo && st != S_IDLE;
  wire [CSW-1:0]  nxt_acc = {acc[CSW-2:0], bit_in};
  wire [BW-1:0]   pad     = BW'(0) - nb;
  wire [CSW-1:0]  fin     = (nb == '0) ? sum : eac(sum, acc << pad);
  wire [CSW-1:0]  rx_cs   = {cs_sh[CSW-2:0], bit_in};
  wire            cs_ok   = rx_cs == ~fin;
  wire [IW-1:0]   nidx    = {idx[IW-2:0], bit_in};
  wire [CW-1:0]   nlen    = len_of(nidx);

  assign idx_o  = idx;
  assign data_o = data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rw <= 1'b0; idx <= '0; cnt <= '0; dlen <= '0;
      sum <= '0; acc <= '0; cs_sh <= '0; nb <= '0; data <= '0;
      wr_stb <= 1'b0; rd_stb <= 1'b0; ack_vld <= 1'b0; ack_val <= 1'b0;
    end else begin
      wr_stb <= 1'b0; rd_stb <= 1'b0; ack_vld <= 1'b0;
      if (st == S_IDLE) begin
        if (cmd_det) begin
          st <= S_HDR; cnt <= '0; sum <= '0; acc <= '0; nb <= '0; data <= '0;
        end
      end else if (tmo) begin
        st <= S_IDLE;
      end else if (take) begin
        if (st != S_CSUM) begin
          nb  <= nb + 1'b1;
          acc <= (nb == BW'(CSW - 1)) ? '0 : nxt_acc;
          if (nb == BW'(CSW - 1)) sum <= eac(sum, nxt_acc);
        end
        case (st)
          S_HDR: begin
            cnt <= cnt + 1'b1;
            if (cnt == '0) rw <= bit_in;
            else idx <= nidx;
            if (cnt == CW'(IW)) begin
              cnt <= '0;
              dlen <= nlen;
              if (!rw) begin
                rd_stb <= 1'b1; st <= S_IDLE;
              end else begin
                st <= (nlen == '0) ? S_CSUM : S_DATA;
              end
            end
          end
          S_DATA: begin
            data <= {data[DW-2:0], bit_in};
            cnt  <= cnt + 1'b1;
            if (cnt == dlen - 1'b1) begin
              cnt <= '0; st <= S_CSUM;
            end
          end
          S_CSUM: begin
            cs_sh <= rx_cs;
            cnt   <= cnt + 1'b1;
            if (cnt == CW'(CSW - 1)) begin
              ack_vld <= 1'b1;
              ack_val <= cs_ok;
              wr_stb  <= cs_ok && writable(idx);
              st      <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_frame_rx_chk.sv
module cfg_frame_rx_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmo,
  input logic [IW-1:0] idx_o,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic          ack_vld,
  input logic          ack_val
);
  AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ack_vld && ack_val); // R6
  AST_NACK_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld && !ack_val |-> !wr_stb); // R7
  AST_RD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !ack_vld && !wr_stb); // R3
  AST_NO_RO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !(idx_o inside {4'd0, 4'd1, 4'd12, 4'd14, 4'd15})); // R8
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |=> !ack_vld); // R9
  AST_TMO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !wr_stb && !rd_stb && !ack_vld); // R11
endmodule

bind cfg_frame_rx cfg_frame_rx_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmo(tmo), .idx_o(idx_o),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .ack_vld(ack_vld), .ack_val(ack_val)
);

// File: tb/cfg_frame_rx_bench.sv
module cfg_frame_rx_bench;
  localparam int DW = 1024;

  logic clk = 0, rst_n = 0, cmd_det = 0, bit_vld = 0, bit_in = 0, tmo = 0;
  logic [3:0] idx_o;
  logic [DW-1:0] data_o;
  logic wr_stb, rd_stb, ack_vld, ack_val;

  cfg_frame_rx u_cfg_frame_rx (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int n_wr = 0, n_rd = 0, n_ack = 0;
  logic cap_ack;
  logic [3:0] cap_idx, cap_ridx;
  logic [DW-1:0] cap_data;
  logic fb [0:1199];
  int nf;

  always @(negedge clk) if (rst_n) begin
    if (wr_stb) begin n_wr++; cap_data = data_o; cap_idx = idx_o; end
    if (rd_stb) begin n_rd++; cap_ridx = idx_o; end
    if (ack_vld) begin n_ack++; cap_ack = ack_val; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  function automatic int len_of(input logic [3:0] i);
    int t [16] = '{8, 24, 8, 18, 8, 124, 124, 42, 56, 160, 46, 8, 1024, 352, 0, 16};
    return t[i];
  endfunction

  function automatic bit wr_ok(input logic [3:0] i);
    return i != 0 && i != 1 && i != 12 && i != 14 && i != 15;
  endfunction

  function automatic logic [7:0] csum(input int n);
    int total = 0;
    for (int b = 0; b < n; b += 8) begin
      int v = 0;
      for (int k = 0; k < 8; k++) v = (v << 1) | ((b + k < n) ? int'(fb[b + k]) : 0);
      total += v;
    end
    while (total > 255) total = (total & 255) + (total >> 8);
    return ~8'(total);
  endfunction

  task automatic send_bit(input logic b);
    bit_vld = 1; bit_in = b; @(negedge clk); bit_vld = 0;
    if ($urandom % 4 == 0) @(negedge clk);
  endtask

  // mode: 0 good, 1 bad checksum, 2 corrupt data bit, 3 stray cmd_det, 4 timeout, 5 surplus bits
  task automatic run(input bit rw, input logic [3:0] ix, input int mode);
    int len = rw ? len_of(ix) : 0;
    logic [DW-1:0] ed = '0;
    logic [7:0] cs;
    int w0 = n_wr, r0 = n_rd, a0 = n_ack;
    bit good;
    nf = 0;
    fb[nf++] = rw;
    for (int i = 3; i >= 0; i--) fb[nf++] = ix[i];
    for (int i = 0; i < len; i++) begin
      logic d = 1'($urandom);
      fb[nf++] = d; ed = {ed[DW-2:0], d};
    end
    if (rw) begin
      cs = csum(nf);
      if (mode == 1) cs ^= 8'h10;
      for (int i = 7; i >= 0; i--) fb[nf++] = cs[i];
      if (mode == 2) fb[5] = ~fb[5];
    end
    cmd_det = 1; @(negedge clk); cmd_det = 0;
    for (int i = 0; i < nf; i++) begin
      if (mode == 3 && i == nf / 2) begin cmd_det = 1; @(negedge clk); cmd_det = 0; end
      if (mode == 4 && i == nf / 2) begin tmo = 1; @(negedge clk); tmo = 0; break; end
      send_bit(fb[i]);
    end
    if (mode == 5) for (int i = 0; i < 12; i++) send_bit(1'($urandom));
    repeat (3) @(negedge clk);
    if (mode == 4) begin
      chk(n_wr == w0 && n_rd == r0 && n_ack == a0, "R11 timeout leaves no event", n_wr + n_rd + n_ack, w0 + r0 + a0);
    end else if (!rw) begin
      chk(n_rd == r0 + 1, "R3 read request count", n_rd - r0, 1);
      chk(cap_ridx == ix, "R3 read index", cap_ridx, ix);
      chk(n_ack == a0 && n_wr == w0, "R3 read has no ack", n_ack - a0, 0);
    end else begin
      good = (mode != 1 && mode != 2);
      chk(n_ack == a0 + 1, "R9 R10 exactly one ack", n_ack - a0, 1);
      chk(cap_ack == good, good ? "R5 R6 ack value" : "R7 nack value", cap_ack, good);
      chk(n_wr == w0 + (good && wr_ok(ix)), wr_ok(ix) ? "R6 R7 write strobe" : "R8 no strobe", n_wr - w0, good && wr_ok(ix));
      if (good && wr_ok(ix)) begin
        chk(cap_data == ed, "R4 data content", cap_data[63:0], ed[63:0]);
        chk(cap_idx == ix, "R3 write index", cap_idx, ix);
      end
    end
  endtask

  logic [3:0] wl [11] = '{2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 13};

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!wr_stb && !rd_stb && !ack_vld, "R1 strobes low in reset", {wr_stb, rd_stb, ack_vld}, 0);
    rst_n = 1; @(negedge clk);
    chk(data_o == '0 && !ack_vld, "R1 reset state", data_o[63:0], 0);
    for (int i = 0; i < 10; i++) send_bit(1'($urandom));
    repeat (3) @(negedge clk);
    chk(n_wr == 0 && n_rd == 0 && n_ack == 0, "R2 idle bits ignored", n_wr + n_rd + n_ack, 0);
    foreach (wl[i]) run(1, wl[i], 0);
    for (int i = 0; i < 12; i++) run(1, wl[$urandom % 11], int'($urandom % 6));
    run(1, 4'd0, 0); run(1, 4'd1, 0); run(1, 4'd12, 0); run(1, 4'd14, 0); run(1, 4'd15, 0);
    run(1, 4'd14, 1);
    run(0, 4'd9, 0); run(0, 4'd12, 0); run(0, 4'd5, 4);
    run(1, 4'd7, 1); run(1, 4'd8, 2); run(1, 4'd3, 3); run(1, 4'd10, 5);
    run(1, 4'd9, 4); run(1, 4'd9, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule